// File: doc/BRIEF.md
# System Clock Source Selection Controller

This block chooses which of three oscillators (internal, low-speed, high-speed) feeds the system clock. Software drives it through a small register port. One register holds an enable bit per oscillator plus the stabilization settings. A second register holds the 2-bit source select. A third holds the core clock gear. A read-only status register reports which oscillators are ready. Each oscillator counts as ready only when all three hold: its enable bit is set, its running flag from the analog side is high, and its stabilization count has expired.

The controller guards the clock tree against unsafe requests. A source switch toward an oscillator that is not ready is dropped. The enable bit of the oscillator currently in use cannot be cleared. Leaving sleep forces the internal oscillator on and selects it. Leaving halt keeps the configuration untouched. The core clock is delivered as a clock-enable pulse. It fires once every 1, 2, 4 or 8 system cycles and is held low during halt and sleep.

Top module: `clksel_top`

## Requirements
- R1: After reset the enable register (address 0) reads 0x09, the source register (address 1) reads 0, and the gear register (address 2) reads 0. The enable register layout is bit0 internal enable, bit1 low-speed enable, bit2 high-speed enable, bit3 low-speed wait enable, bits5:4 internal wait select.
- R2: A write to address 1 of code 0 (internal), 1 (low-speed) or 2 (high-speed) changes the selection only if the target is ready. Otherwise the readback keeps its previous value.
- R3: A write of code 3 to address 1 is ignored, and the selection never holds 3.
- R4: A write to address 0 that clears the enable bit of the selected oscillator leaves that bit at 1. The other fields of the same write take effect.
- R5: Once enabled and running, the internal oscillator becomes ready after 16, 32, 64 or 128 cycles for wait select 0..3. The high-speed oscillator becomes ready after HIGH_WAIT cycles. Status register (address 3) bit0, bit1 and bit2 report ready for internal, low-speed and high-speed.
- R6: With the low-speed wait enable at 0, the low-speed oscillator is ready in the first cycle after its enable is written, provided its running flag is high. With the wait enable at 1, it waits LOW_WAIT cycles.
- R7: In the first cycle after the sleep input falls, the internal enable reads 1 and the selection reads 0. Any register write in that same cycle is discarded.
- R8: Asserting and releasing halt leaves the enables and the selection unchanged.
- R9: With gear code g at address 2, core_ce pulses once every 2^g system cycles. A gear write restarts the divider.
- R10: core_ce stays low while halt or sleep is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| osc_int_ok | input | 1 | Internal oscillator running flag |
| osc_low_ok | input | 1 | Low-speed oscillator running flag |
| osc_high_ok | input | 1 | High-speed oscillator running flag |
| sleep | input | 1 | Sleep level; its falling edge is the wake event |
| halt | input | 1 | Halt level; gates the core clock |
| src_sel | output | 2 | Source currently in effect |
| core_ce | output | 1 | Core clock-enable pulse from the gear |

## Verification
The wake event from sleep and a register write can land on the same clock edge. The forced internal selection must then win, and the write must vanish. The bench first clears the internal enable while the low-speed source is selected. It then enters sleep and drops sleep on the very cycle that a new enable-register write is strobed. It reads back an enable value holding only the forced internal bit plus the pre-sleep low-speed bit, and a selection of 0. A checker property covers every wake cycle in the same way.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
package clksel_pkg;

    typedef enum logic [1:0] {
        SRC_INT  = 2'd0,
        SRC_LOW  = 2'd1,
        SRC_HIGH = 2'd2,
        SRC_RSVD = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        REG_ENA  = 2'd0,
        REG_SRC  = 2'd1,
        REG_GEAR = 2'd2,
        REG_STAT = 2'd3
    } reg_e;

    localparam int NUM_OSC = 3;

    // Packed so that the field order matches the enable register bits [5:0].
    typedef struct packed {
        logic [1:0] int_wait;
        logic       low_wait_en;
        logic       high_en;
        logic       low_en;
        logic       int_en;
    } osc_cfg_t;

    localparam osc_cfg_t CFG_RESET = '{int_wait: 2'd0, low_wait_en: 1'b1,
                                       high_en: 1'b0, low_en: 1'b0, int_en: 1'b1};

    function automatic int int_wait_cycles(input logic [1:0] sel);
        return 16 << sel;
    endfunction

    function automatic logic [3:0] gear_period_m1(input logic [1:0] g);
        return 4'((1 << g) - 1);
    endfunction

endpackage

// File: rtl/clksel_stab.sv
`timescale 1ns/1ps
module clksel_stab #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             ready
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q < limit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign ready = run && (cnt_q >= limit);
endmodule

// File: rtl/clksel_gear.sv
`timescale 1ns/1ps
module clksel_gear (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] gear,
    input  logic       restart,
    input  logic       run,
    output logic       ce
);
    import clksel_pkg::*;

    logic [3:0] div_q;
    logic       tick;

    assign tick = (div_q == gear_period_m1(gear));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign ce = tick && run;
endmodule

// File: rtl/clksel_top.sv
`timescale 1ns/1ps
module clksel_top #(
    parameter int HIGH_WAIT = 64,
    parameter int LOW_WAIT  = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       osc_int_ok,
    input  logic       osc_low_ok,
    input  logic       osc_high_ok,
    input  logic       sleep,
    input  logic       halt,
    output logic [1:0] src_sel,
    output logic       core_ce
);
    import clksel_pkg::*;

    localparam int MAX_A    = (HIGH_WAIT > LOW_WAIT) ? HIGH_WAIT : LOW_WAIT;
    localparam int MAX_WAIT = (MAX_A > 128) ? MAX_A : 128;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);

    osc_cfg_t   cfg_q;
    src_e       src_q;
    logic [1:0] gear_q;
    logic       sleep_q;
    logic       wake;

    logic [NUM_OSC-1:0] en_vec;
    logic [NUM_OSC-1:0] ok_vec;
    logic [NUM_OSC-1:0] rdy;
    logic [3:0]         rdy_ext;
    logic [CNT_W-1:0]   lim [NUM_OSC];

    osc_cfg_t ena_wr;
    logic     src_ok;
    logic     gear_wr;

    assign wake    = sleep_q && !sleep;
    assign en_vec  = {cfg_q.high_en, cfg_q.low_en, cfg_q.int_en};
    assign ok_vec  = {osc_high_ok, osc_low_ok, osc_int_ok};
    assign rdy_ext = {1'b0, rdy};

    // Wait lengths per oscillator, indexed by source code.
    always_comb begin
        lim[SRC_INT]  = CNT_W'(int_wait_cycles(cfg_q.int_wait));
        lim[SRC_LOW]  = cfg_q.low_wait_en ? CNT_W'(LOW_WAIT) : '0;
        lim[SRC_HIGH] = CNT_W'(HIGH_WAIT);
    end

    for (genvar i = 0; i < NUM_OSC; i++) begin : g_stab
        clksel_stab #(.CNT_W(CNT_W)) u_stab (
            .clk   (clk),
            .rst   (rst),
            .run   (en_vec[i] && ok_vec[i]),
            .limit (lim[i]),
            .ready (rdy[i])
        );
    end

    // Enable write with the active oscillator's bit pinned high.
    always_comb begin
        ena_wr = osc_cfg_t'(wdata[5:0]);
        case (src_q)
            SRC_INT:  ena_wr.int_en  = 1'b1;
            SRC_LOW:  ena_wr.low_en  = 1'b1;
            SRC_HIGH: ena_wr.high_en = 1'b1;
            default:  ;
        endcase
    end

    assign src_ok  = (wdata[1:0] != SRC_RSVD) && rdy_ext[wdata[1:0]];
    assign gear_wr = wr_en && !wake && (addr == REG_GEAR);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= CFG_RESET;
            src_q   <= SRC_INT;
            gear_q  <= 2'd0;
            sleep_q <= 1'b0;
        end else begin
            sleep_q <= sleep;
            if (wake) begin
                cfg_q.int_en <= 1'b1;
                src_q        <= SRC_INT;
            end else if (wr_en) begin
                case (reg_e'(addr))
                    REG_ENA:  cfg_q  <= ena_wr;
                    REG_SRC:  if (src_ok) src_q <= src_e'(wdata[1:0]);
                    REG_GEAR: gear_q <= wdata[1:0];
                    default:  ;
                endcase
            end
        end
    end

    clksel_gear u_gear (
        .clk     (clk),
        .rst     (rst),
        .gear    (gear_q),
        .restart (gear_wr),
        .run     (!halt && !sleep),
        .ce      (core_ce)
    );

    always_comb begin
        case (reg_e'(addr))
            REG_ENA:  rdata = {2'b00, cfg_q};
            REG_SRC:  rdata = {6'b0, src_q};
            REG_GEAR: rdata = {6'b0, gear_q};
            default:  rdata = {5'b0, rdy};
        endcase
    end

    assign src_sel = src_q;
endmodule

// File: rtl/clksel_chk.sv
`timescale 1ns/1ps
module clksel_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [1:0] addr,
    input logic [7:0] wdata,
    input logic       sleep,
    input logic       halt,
    input logic       wake,
    input logic [1:0] src_sel,
    input logic       core_ce,
    input logic [2:0] en_vec,
    input logic [2:0] rdy,
    input logic [1:0] gear
);
    logic [3:0] rdy_x;
    logic [3:0] en_x;
    assign rdy_x = {1'b0, rdy};
    assign en_x  = {1'b0, en_vec};

    // R2 / R3: a rejected select write leaves the selection alone
    p_reject_keeps_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd1 && !wake && (wdata[1:0] == 2'd3 || !rdy_x[wdata[1:0]]))
        |=> $stable(src_sel));

    p_no_reserved_r3: assert property (@(posedge clk) disable iff (rst)
        src_sel != 2'd3);

    p_active_enabled_r4: assert property (@(posedge clk) disable iff (rst)
        en_x[src_sel]);

    p_wake_forces_r7: assert property (@(posedge clk) disable iff (rst)
        wake |=> (src_sel == 2'd0) && en_vec[0]);

    p_halt_keeps_r8: assert property (@(posedge clk) disable iff (rst)
        (halt && !wr_en && !wake) |=> $stable(src_sel) && $stable(en_vec));

    p_full_speed_r9: assert property (@(posedge clk) disable iff (rst)
        (gear == 2'd0 && !halt && !sleep) |-> core_ce);

    p_gated_r10: assert property (@(posedge clk) disable iff (rst)
        (halt || sleep) |-> !core_ce);
endmodule

bind clksel_top clksel_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .sleep   (sleep),
    .halt    (halt),
    .wake    (wake),
    .src_sel (src_sel),
    .core_ce (core_ce),
    .en_vec  (en_vec),
    .rdy     (rdy),
    .gear    (gear_q)
);

// File: tb/tb_clksel_top.sv
`timescale 1ns/1ps
module tb_clksel_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       osc_int_ok = 1'b1;
    logic       osc_low_ok = 1'b0;
    logic       osc_high_ok = 1'b0;
    logic       sleep = 1'b0;
    logic       halt = 1'b0;
    logic [1:0] src_sel;
    logic       core_ce;

    int checks = 0;
    int errors = 0;
    logic mon_req = 1'b0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    clksel_top #(.HIGH_WAIT(64), .LOW_WAIT(256)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .osc_int_ok(osc_int_ok), .osc_low_ok(osc_low_ok),
        .osc_high_ok(osc_high_ok), .sleep(sleep), .halt(halt),
        .src_sel(src_sel), .core_ce(core_ce)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected readbacks just after the edge following the request
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mon_req && sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check(it.tag, int'(rdata), int'(it.exp));
            end
        end
    end

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        item_t it;
        it.exp = e; it.tag = tag;
        addr = a; wr_en = 1'b0;
        sb_q.push_back(it);
        mon_req = 1'b1;
        @(negedge clk);
        mon_req = 1'b0;
    endtask

    task automatic count_ce(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            cnt += int'(core_ce);
        end
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        expect_rd(2'd0, 8'h09, "R1 enable reset");
        expect_rd(2'd1, 8'h00, "R1 select reset");
        expect_rd(2'd2, 8'h00, "R1 gear reset");
        repeat (20) @(negedge clk);

        // R5 high-speed wait, R2 early switch rejected
        osc_high_ok = 1'b1;
        reg_wr(2'd0, 8'h0D);
        reg_wr(2'd1, 8'h02);
        repeat (61) @(negedge clk);
        expect_rd(2'd3, 8'h01, "R5 high not ready at 63");
        expect_rd(2'd3, 8'h05, "R5 high ready at 64");
        expect_rd(2'd1, 8'h00, "R2 early switch rejected");
        reg_wr(2'd1, 8'h02);
        expect_rd(2'd1, 8'h02, "R2 switch to high");

        // R3 reserved code
        reg_wr(2'd1, 8'h03);
        expect_rd(2'd1, 8'h02, "R3 reserved ignored");

        // R4 active enable pinned
        reg_wr(2'd0, 8'h00);
        expect_rd(2'd0, 8'h04, "R4 high enable kept");
        reg_wr(2'd1, 8'h00);
        expect_rd(2'd1, 8'h02, "R2 disabled target rejected");

        // R6 low-speed with wait skipped
        osc_low_ok = 1'b1;
        reg_wr(2'd0, 8'h06);
        expect_rd(2'd3, 8'h06, "R6 low ready at once");
        reg_wr(2'd1, 8'h01);
        expect_rd(2'd1, 8'h01, "R2 switch to low");
        reg_wr(2'd0, 8'h00);
        expect_rd(2'd0, 8'h02, "R4 low enable kept");

        // R5 internal wait select 1 -> 32 cycles
        reg_wr(2'd0, 8'h13);
        repeat (30) @(negedge clk);
        expect_rd(2'd3, 8'h02, "R5 int not ready at 31");
        expect_rd(2'd3, 8'h03, "R5 int ready at 32");
        reg_wr(2'd0, 8'h33);
        expect_rd(2'd3, 8'h02, "R5 int wait 128 drops ready");

        // R8 / R10 halt
        halt = 1'b1;
        count_ce(10, n);
        check("R10 no ce in halt", n, 0);
        halt = 1'b0;
        @(negedge clk);
        expect_rd(2'd1, 8'h01, "R8 select kept after halt");
        expect_rd(2'd0, 8'h33, "R8 enables kept after halt");

        // R9 gear ratios
        for (int g = 0; g < 4; g++) begin
            reg_wr(2'd2, 8'(g));
            count_ce(64, n);
            check($sformatf("R9 gear %0d pulses", g), n, 64 >> g);
        end
        expect_rd(2'd2, 8'h03, "R9 gear readback");

        // R7 / R10 sleep, wake collides with a write
        reg_wr(2'd0, 8'h02);
        expect_rd(2'd0, 8'h02, "R4 int cleared while low active");
        sleep = 1'b1;
        count_ce(12, n);
        check("R10 no ce in sleep", n, 0);
        sleep = 1'b0;
        reg_wr(2'd0, 8'h06);
        expect_rd(2'd0, 8'h03, "R7 wake forces int, write dropped");
        expect_rd(2'd1, 8'h00, "R7 wake selects internal");

        repeat (3) @(negedge clk);
        check("scoreboard drained", sb_q.size(), 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule